// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block keeps wall-clock time as one 47-bit count. The upper 32 bits are whole seconds and the lower 15 bits are the fraction of a second. A one-cycle strobe from a 32.768 kHz reference advances the count by one. Software sets the time through a small write port. It reads the time, the alarm and the flags back through a combinational read port.

The counter runs only when four things hold: it is enabled, its overflow flag is clear, its power-loss ("invalid") flag is clear, and its seconds word has been loaded since reset. It also stops while a security monitor asserts a halt input, so that the time of the security event is preserved. To set the time, software zeroes the fraction, writes the seconds word, and then enables the counter. Writing the seconds word also arms the counter.

A 32-bit alarm compares against the seconds. When the seconds become equal to the alarm, the block sets a sticky alarm flag. An interrupt follows that flag when the interrupt is enabled. Lock bits can freeze the time registers while the counter is disabled.

Top module: `sec_alarm_top`

Register addresses: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status.
Control bits: bit0 run enable, bit1 alarm interrupt enable, bit2 soft lock, bit3 hard lock.
Status bits: bit0 alarm flag, bit1 overflow, bit2 invalid. Writing 1 to a status bit clears it.

## Requirements
- R1: After reset the block reads seconds 0, fraction 0, alarm 32'hFFFF_FFFF, control 0, and status 4 (invalid set, all other flags clear), with the interrupt output low.
- R2: On each tick while running, the 47-bit value {seconds, fraction} increases by one, so fraction 15'h7FFF rolls to 0 and carries into the seconds.
- R3: A tick does not change the count while any of these holds: run enable (control bit0) is clear, invalid (status bit2) is set, the seconds word has not been written since reset, the halt input is high, or overflow (status bit1) is set.
- R4: A write to address 0 loads the seconds, leaves the fraction unchanged and arms the counter. A write to address 1 loads the fraction.
- R5: A tick at the all-ones count wraps the count to zero and sets overflow (status bit1). The count then holds at zero until overflow is cleared by writing 1 to it.
- R6: The alarm fraction (address 3) always reads 0, and writes to it are ignored.
- R7: An alarm value of 32'hFFFF_FFFF means no alarm, and the alarm flag does not set even when the seconds equal it.
- R8: The alarm flag (status bit0) sets in the cycle after the seconds become equal to the alarm. It stays set until 1 is written to bit0; writing 0 leaves it set.
- R9: The interrupt output is high exactly when the alarm flag and the interrupt enable (control bit1) are both set.
- R10: While run enable is clear and the soft lock (bit2) or the hard lock (bit3) is set, writes to the seconds and fraction are ignored. The hard lock cannot be cleared by a write.
- R11: Writing 1 to status bit2 clears the invalid flag, and nothing but reset sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| halt_i | input | 1 | Security-monitor halt; freezes the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data for rd_addr_i (combinational) |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
A wrong run qualifier shows up at the seconds and fraction read addresses on the first tick after the error: the count moves when it should hold, or holds when it should move. A broken compare edge or a broken flag register shows in status bit0 and in the interrupt pin one cycle after the seconds reach the alarm. A corrupted overflow or lock state appears on the next tick, or on the next write that the state should have blocked.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;
  typedef enum logic [2:0] {
    A_SECS      = 3'd0,
    A_FRAC      = 3'd1,
    A_ALRM      = 3'd2,
    A_ALRM_FRAC = 3'd3,
    A_CTRL      = 3'd4,
    A_STAT      = 3'd5
  } reg_addr_e;

  localparam int C_RUN   = 0;
  localparam int C_IEN   = 1;
  localparam int C_SLOCK = 2;
  localparam int C_HLOCK = 3;
  localparam int CTRL_W  = 4;

  localparam int S_ALARM = 0;
  localparam int S_OVF   = 1;
  localparam int S_INVAL = 2;
  localparam int STAT_W  = 3;
endpackage

// File: rtl/sec_time_count.sv
module sec_time_count #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              ld_sec_i,
  input  logic              ld_frac_i,
  input  logic [SEC_W-1:0]  sec_d_i,
  input  logic [FRAC_W-1:0] frac_d_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              wrap_o
);
  localparam int TOT_W = SEC_W + FRAC_W;

  logic [TOT_W-1:0] cnt_q;

  function automatic logic [TOT_W-1:0] next_count(input logic [TOT_W-1:0] c);
    return c + {{(TOT_W-1){1'b0}}, 1'b1};
  endfunction

  assign sec_o  = cnt_q[TOT_W-1:FRAC_W];
  assign frac_o = cnt_q[FRAC_W-1:0];
  assign wrap_o = inc_i && (cnt_q == {TOT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_sec_i || ld_frac_i) begin
      if (ld_sec_i)  cnt_q[TOT_W-1:FRAC_W] <= sec_d_i;
      if (ld_frac_i) cnt_q[FRAC_W-1:0]     <= frac_d_i;
    end else if (inc_i) begin
      cnt_q <= next_count(cnt_q);
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_sec_i && !ld_frac_i) |=> (cnt_q == next_count($past(cnt_q))));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !ld_sec_i && !ld_frac_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sec_alarm_cmp.sv
module sec_alarm_cmp #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SEC_W-1:0] alarm_i,
  input  logic             clr_i,
  output logic             hit_o,
  output logic             flag_o
);
  logic match_now;
  logic match_q;
  logic alarm_live;

  assign match_now  = (sec_i == alarm_i);
  assign alarm_live = (alarm_i != {SEC_W{1'b1}});
  assign hit_o      = match_now && !match_q && alarm_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      match_q <= match_now;
      if (hit_o)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  assert_no_hit_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_i == {SEC_W{1'b1}}) |-> !hit_o);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> flag_o);
endmodule

// File: rtl/sec_alarm_top.sv
module sec_alarm_top
  import sec_alarm_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [SEC_W-1:0] wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [SEC_W-1:0] rd_data_o,
  output logic             alarm_irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [SEC_W-1:0]  alarm_q;
  logic              ovf_q, inval_q, armed_q;
  logic [SEC_W-1:0]  sec;
  logic [FRAC_W-1:0] frac;
  logic              wrap, hit, flag;

  logic time_wr_ok, wr_sec, wr_frac, wr_alrm, wr_ctrl, wr_stat;
  logic run, inc;

  assign time_wr_ok = ctrl_q[C_RUN] || !(ctrl_q[C_SLOCK] || ctrl_q[C_HLOCK]);
  assign wr_sec     = wr_en_i && (reg_addr_e'(wr_addr_i) == A_SECS) && time_wr_ok;
  assign wr_frac    = wr_en_i && (reg_addr_e'(wr_addr_i) == A_FRAC) && time_wr_ok;
  assign wr_alrm    = wr_en_i && (reg_addr_e'(wr_addr_i) == A_ALRM);
  assign wr_ctrl    = wr_en_i && (reg_addr_e'(wr_addr_i) == A_CTRL);
  assign wr_stat    = wr_en_i && (reg_addr_e'(wr_addr_i) == A_STAT);

  assign run = ctrl_q[C_RUN] && !ovf_q && !inval_q && armed_q && !halt_i;
  assign inc = tick_i && run && !wr_sec && !wr_frac;

  sec_time_count #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .ld_sec_i(wr_sec), .ld_frac_i(wr_frac),
    .sec_d_i(wr_data_i), .frac_d_i(wr_data_i[FRAC_W-1:0]),
    .sec_o(sec), .frac_o(frac), .wrap_o(wrap)
  );

  sec_alarm_cmp #(.SEC_W(SEC_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .sec_i(sec), .alarm_i(alarm_q),
    .clr_i(wr_stat && wr_data_i[S_ALARM]), .hit_o(hit), .flag_o(flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      alarm_q <= '1;
      ovf_q   <= 1'b0;
      inval_q <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q[C_HLOCK-1:0] <= wr_data_i[C_HLOCK-1:0];
        ctrl_q[C_HLOCK]     <= ctrl_q[C_HLOCK] | wr_data_i[C_HLOCK];
      end
      if (wr_alrm) alarm_q <= wr_data_i;
      if (wr_sec)  armed_q <= 1'b1;
      if (wrap)                             ovf_q <= 1'b1;
      else if (wr_stat && wr_data_i[S_OVF]) ovf_q <= 1'b0;
      if (wr_stat && wr_data_i[S_INVAL])    inval_q <= 1'b0;
    end
  end

  assign alarm_irq_o = flag && ctrl_q[C_IEN];

  always_comb begin
    rd_data_o = '0;
    case (reg_addr_e'(rd_addr_i))
      A_SECS:  rd_data_o = sec;
      A_FRAC:  rd_data_o = {{(SEC_W-FRAC_W){1'b0}}, frac};
      A_ALRM:  rd_data_o = alarm_q;
      A_CTRL:  rd_data_o = {{(SEC_W-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:  rd_data_o = {{(SEC_W-STAT_W){1'b0}}, inval_q, ovf_q, flag};
      default: rd_data_o = '0;
    endcase
  end

  assert_ovf_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (sec == '0 && frac == '0));

  assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !wr_sec && !wr_frac) |=> ($stable(sec) && $stable(frac)));

  assert_hard_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[C_HLOCK] |=> ctrl_q[C_HLOCK]);

  assert_inval_no_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inval_q |=> !inval_q);
endmodule

// File: tb/test_sec_alarm_top.sv
`timescale 1ns/1ps
module test_sec_alarm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, halt_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        alarm_irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  sec_alarm_top i_sec_alarm_top (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .halt_i(halt_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .alarm_irq_o(alarm_irq_o)
  );

  // monitor: pops expected items and compares after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'b0, alarm_irq_o} : rd_data_o;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr_i = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #3;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #3;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(0, 32'h0, "R1 secs");
    chk(1, 32'h0, "R1 frac");
    chk(2, 32'hFFFF_FFFF, "R1 alarm");
    chk(4, 32'h0, "R1 ctrl");
    chk(5, 32'h4, "R1 status");
    chk_irq(1'b0, "R1 irq");
    // R3: enabled but not armed and invalid
    wr(4, 32'h1);
    tick(1);
    chk(1, 32'h0, "R3 unarmed");
    // R4 loads
    wr(1, 32'h7FFE);
    wr(0, 32'd10);
    chk(0, 32'd10, "R4 secs load");
    chk(1, 32'h7FFE, "R4 frac kept");
    tick(1);
    chk(1, 32'h7FFE, "R3 invalid stops");
    wr(5, 32'h4);
    chk(5, 32'h0, "R11 invalid cleared");
    tick(1);
    chk(1, 32'h7FFF, "R2 step");
    halt_i = 1'b1;
    tick(1);
    chk(1, 32'h7FFF, "R3 halt");
    halt_i = 1'b0;
    wr(4, 32'h0);
    tick(1);
    chk(1, 32'h7FFF, "R3 disabled");
    // alarm at 11, irq enabled
    wr(2, 32'd11);
    wr(4, 32'h3);
    tick(1);
    chk(0, 32'd11, "R2 carry secs");
    chk(1, 32'h0, "R2 carry frac");
    chk(5, 32'h1, "R8 flag set");
    chk_irq(1'b1, "R9 irq high");
    wr(5, 32'h0);
    chk(5, 32'h1, "R8 write 0 keeps flag");
    wr(5, 32'h1);
    chk(5, 32'h0, "R8 w1c");
    chk_irq(1'b0, "R9 irq low");
    wr(3, 32'h5);
    chk(3, 32'h0, "R6 alarm frac zero");
    chk(2, 32'd11, "R6 alarm secs intact");
    // masked interrupt
    wr(4, 32'h1);
    wr(0, 32'd5);
    wr(2, 32'd5);
    chk(5, 32'h1, "R8 flag on alarm write");
    chk_irq(1'b0, "R9 masked");
    wr(5, 32'h1);
    // R7 disabled alarm
    wr(2, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    chk(5, 32'h0, "R7 no alarm");
    // R5 overflow
    wr(1, 32'h7FFF);
    tick(1);
    chk(0, 32'h0, "R5 wrap secs");
    chk(1, 32'h0, "R5 wrap frac");
    chk(5, 32'h2, "R5 ovf set");
    tick(2);
    chk(1, 32'h0, "R5 hold");
    wr(5, 32'h2);
    tick(1);
    chk(1, 32'h1, "R5 resume");
    // R10 locks
    wr(4, 32'h5);
    wr(0, 32'd40);
    chk(0, 32'd40, "R10 enabled write ok");
    wr(4, 32'h4);
    wr(0, 32'd50);
    wr(1, 32'h3);
    chk(0, 32'd40, "R10 soft lock secs");
    chk(1, 32'h1, "R10 soft lock frac");
    wr(4, 32'h8);
    wr(4, 32'h0);
    chk(4, 32'h8, "R10 hard lock sticky");
    wr(0, 32'd60);
    chk(0, 32'd40, "R10 hard lock secs");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule